// File: doc/BRIEF.md
# Replicated-Bank Register File with Last-Writer Tracking

This block is a 32-entry, 32-bit integer register file with two write ports and five read ports. Four read ports feed instruction operands. The fifth serves a debug view and behaves exactly like the others. Every port runs on one clock, and no clock is multiplied or time-shared.

The storage is a grid of simple RAM banks. Each bank has one write port and one synchronous read port. The grid has one row for each write port and one column for each read port. A write is copied into every bank of its row, so each read port has a private copy of what each write port has stored.

A small table keeps, for each register, the index of the write port that wrote it last. A read port looks up its address in every row and in the table in the same cycle, then picks the row the table names. Register 0 reads as zero and cannot be written. A read issued in the same cycle as a write to the same register returns the old value. The surrounding pipeline must forward results for that two-cycle window.

Top module: `lvt_regfile`

## Requirements
- R1: The file holds 32 registers of 32 bits. It has 2 write ports and 5 read ports. Read port index 4 is the debug port and follows the same rules as ports 0 to 3.
- R2: A write is taken at the rising edge where `we_i[w]` is 1, with address `waddr_i[w]` and data `wdata_i[w]`. A read address sampled at a later rising edge gives that data on `rdata_o[p]` after that edge, so a read has one cycle of latency.
- R3: A read address sampled at the same edge as a write to that register returns the previous contents. A read sampled at the next edge returns the new data, so a write becomes visible two cycles after it is issued.
- R4: If both write ports write the same register at the same edge, the register afterwards holds the data from write port 1.
- R5: A read of address 0 always returns zero. A write to address 0 changes neither register 0 nor any other register.
- R6: While `rst_ni` is low, every `rdata_o` port shows zero.
- R7: The five read ports are independent. Any mix of equal or different addresses, read in the same cycle and combined with writes, gives each port the current contents of its own register.
- R8: Across cycles, the most recent write to a register wins, whichever write port made it. A write from port 0 that follows an earlier write from port 1 is the one that is read back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock for all ports |
| rst_ni | input | 1 | Asynchronous reset, active low |
| we_i | input | 2 | Write enable, one bit per write port |
| waddr_i | input | 2x5 | Write address per write port |
| wdata_i | input | 2x32 | Write data per write port |
| raddr_i | input | 5x5 | Read address per read port; index 4 is the debug port |
| rdata_o | output | 5x32 | Read data per read port, one cycle after the address |

## Verification
The hardest case is a register whose latest value sits in the row other than the one that wrote it first. The table must then steer the read away from a stale copy that is still present in the other row. Directed sequences write the same register from port 1 and then from port 0, and the reverse. They also write it from both ports in one cycle, and read it back on all five ports, including in the same cycle as the write. A long random phase then confines addresses to a few registers, so that writes alternating between rows and same-cycle collisions happen often.

// File: rtl/regfile_pkg.sv
package regfile_pkg;
  localparam int unsigned NREG_DEF = 32;
  localparam int unsigned DW_DEF   = 32;
  localparam int unsigned NWR_DEF  = 2;
  localparam int unsigned NRD_DEF  = 5;

  function automatic int unsigned sel_w(input int unsigned n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction
endpackage

// File: rtl/lvt_bank.sv
module lvt_bank #(
  parameter int unsigned NREG = 32,
  parameter int unsigned DW   = 32,
  localparam int unsigned AW  = $clog2(NREG)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic [AW-1:0] raddr_i,
  output logic [DW-1:0] rdata_o
);
  logic [DW-1:0] mem_q [NREG];

  // read-before-write on a same-edge address match
  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[waddr_i] <= wdata_i;
    rdata_o <= mem_q[raddr_i];
  end

  p_bank_store_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i |=> mem_q[$past(waddr_i)] == $past(wdata_i));
endmodule

// File: rtl/lvt_table.sv
module lvt_table #(
  parameter int unsigned NREG = 32,
  parameter int unsigned NWR  = 2,
  parameter int unsigned NRD  = 5,
  localparam int unsigned AW   = $clog2(NREG),
  localparam int unsigned SELW = regfile_pkg::sel_w(NWR)
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic [NWR-1:0]          we_i,
  input  logic [NWR-1:0][AW-1:0]  waddr_i,
  input  logic [NRD-1:0][AW-1:0]  raddr_i,
  output logic [NRD-1:0][SELW-1:0] sel_o
);
  logic [SELW-1:0] lvt_q [NREG];

  // higher write port index is applied last and wins a collision
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < NREG; i++) lvt_q[i] <= '0;
      sel_o <= '0;
    end else begin
      for (int w = 0; w < NWR; w++)
        if (we_i[w]) lvt_q[waddr_i[w]] <= SELW'(w);
      for (int p = 0; p < NRD; p++)
        sel_o[p] <= lvt_q[raddr_i[p]];
    end
  end

  p_top_port_wins_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i[NWR-1] |=> lvt_q[$past(waddr_i[NWR-1])] == SELW'(NWR-1));
endmodule

// File: rtl/lvt_regfile.sv
module lvt_regfile #(
  parameter int unsigned NREG = regfile_pkg::NREG_DEF,
  parameter int unsigned DW   = regfile_pkg::DW_DEF,
  parameter int unsigned NWR  = regfile_pkg::NWR_DEF,
  parameter int unsigned NRD  = regfile_pkg::NRD_DEF,
  localparam int unsigned AW   = $clog2(NREG),
  localparam int unsigned SELW = regfile_pkg::sel_w(NWR)
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic [NWR-1:0]          we_i,
  input  logic [NWR-1:0][AW-1:0]  waddr_i,
  input  logic [NWR-1:0][DW-1:0]  wdata_i,
  input  logic [NRD-1:0][AW-1:0]  raddr_i,
  output logic [NRD-1:0][DW-1:0]  rdata_o
);
  logic [NWR-1:0]          we_eff;
  logic [DW-1:0]           bank_rd [NWR][NRD];
  logic [NRD-1:0][SELW-1:0] sel;
  logic [NRD-1:0]          zero_q;
  logic [NRD-1:0]          hit_now;

  // register 0 is never written
  always_comb
    for (int w = 0; w < NWR; w++) we_eff[w] = we_i[w] && (waddr_i[w] != '0);

  for (genvar w = 0; w < NWR; w++) begin : g_row
    for (genvar p = 0; p < NRD; p++) begin : g_col
      lvt_bank #(.NREG(NREG), .DW(DW)) u_bank (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .we_i    (we_eff[w]),
        .waddr_i (waddr_i[w]),
        .wdata_i (wdata_i[w]),
        .raddr_i (raddr_i[p]),
        .rdata_o (bank_rd[w][p])
      );
    end
  end

  lvt_table #(.NREG(NREG), .NWR(NWR), .NRD(NRD)) u_lvt (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (we_eff),
    .waddr_i (waddr_i),
    .raddr_i (raddr_i),
    .sel_o   (sel)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) zero_q <= '1;
    else for (int p = 0; p < NRD; p++) zero_q[p] <= (raddr_i[p] == '0);
  end

  always_comb begin
    for (int p = 0; p < NRD; p++)
      rdata_o[p] = zero_q[p] ? '0 : bank_rd[sel[p]][p];
  end

  // assertion helper: some write targets this read address now
  always_comb begin
    for (int p = 0; p < NRD; p++) begin
      hit_now[p] = 1'b0;
      for (int w = 0; w < NWR; w++)
        if (we_eff[w] && waddr_i[w] == raddr_i[p]) hit_now[p] = 1'b1;
    end
  end

  for (genvar p = 0; p < NRD; p++) begin : g_chk
    p_zero_read_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      raddr_i[p] == '0 |=> rdata_o[p] == '0);
    p_write_visible_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      we_eff[NWR-1] ##1 (raddr_i[p] == $past(waddr_i[NWR-1]) && !hit_now[p])
      |=> rdata_o[p] == $past(wdata_i[NWR-1], 2));
  end
endmodule

// File: tb/sim_lvt_regfile.sv
module sim_lvt_regfile;
  localparam int CLK_P = 10;
  localparam int NRD = 5;
  localparam int NWR = 2;

  typedef struct {
    int          port;
    logic [31:0] exp;
    string       tag;
  } item_t;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic [NWR-1:0]        we = '0;
  logic [NWR-1:0][4:0]   wa = '0;
  logic [NWR-1:0][31:0]  wd = '0;
  logic [NRD-1:0][4:0]   ra = '0;
  logic [NRD-1:0][31:0]  rd;

  int total = 0;
  int bad = 0;
  bit done = 0;
  string tag = "R1";
  item_t q[$];
  logic [31:0] ref_q [32];
  bit known [32];

  always #(CLK_P/2) clk = ~clk;

  lvt_regfile u0 (
    .clk_i(clk), .rst_ni(rst_ni), .we_i(we), .waddr_i(wa),
    .wdata_i(wd), .raddr_i(ra), .rdata_o(rd)
  );

  task automatic check(input string t, input int p, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s port=%0d act=%h exp=%h", t, p, act, exp);
    end
  endtask

  // driver: applies one cycle and queues the expected read results
  task automatic drive(input logic [1:0] w_en, input logic [1:0][4:0] w_a,
                       input logic [1:0][31:0] w_d, input logic [4:0][4:0] r_a);
    item_t it;
    @(negedge clk);
    we = w_en; wa = w_a; wd = w_d; ra = r_a;
    for (int p = 0; p < NRD; p++) begin
      if (r_a[p] == 0 || known[r_a[p]]) begin
        it.port = p;
        it.exp  = (r_a[p] == 0) ? 32'h0 : ref_q[r_a[p]];
        it.tag  = tag;
        q.push_back(it);
      end
    end
    for (int w = 0; w < NWR; w++)
      if (w_en[w] && w_a[w] != 0) begin
        ref_q[w_a[w]] = w_d[w];
        known[w_a[w]] = 1'b1;
      end
  endtask

  task automatic rd_all(input logic [4:0] a);
    drive(2'b00, '0, '0, {5{a}});
  endtask

  // monitor
  initial begin
    item_t it;
    forever begin
      @(posedge clk);
      #2;
      while (q.size() > 0) begin
        it = q.pop_front();
        check(it.tag, it.port, rd[it.port], it.exp);
      end
    end
  end

  initial begin
    #(CLK_P * 200000);
    if (!done) begin
      bad++;
      total++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 32; i++) begin
      ref_q[i] = '0;
      known[i] = 1'b0;
    end
    // R6: outputs are zero during reset
    ra = {5'd3, 5'd7, 5'd1, 5'd31, 5'd9};
    repeat (3) @(negedge clk);
    for (int p = 0; p < NRD; p++) check("R6", p, rd[p], 32'h0);
    rst_ni = 1'b1;

    // R2: fill registers, alternating rows
    tag = "R2";
    for (int i = 1; i < 32; i += 2)
      drive(2'b11, {5'(i + 1 < 32 ? i + 1 : 1), 5'(i)},
            {32'hA000_0000 + 32'(i + 1), 32'h5000_0000 + 32'(i)}, '0);
    // R1, R7: read every register on every port, mixed addresses
    tag = "R1";
    for (int i = 0; i < 32; i++) rd_all(5'(i));
    tag = "R7";
    for (int i = 0; i < 32; i++)
      drive(2'b00, '0, '0, {5'(i), 5'(31 - i), 5'(i ^ 5), 5'((i + 7) % 32), 5'(i / 2)});

    // R3: same-edge read returns old, next read returns new
    tag = "R3";
    drive(2'b01, {5'd0, 5'd5}, {32'h0, 32'hDEAD_0005}, {5{5'd5}});
    rd_all(5'd5);
    drive(2'b10, {5'd6, 5'd0}, {32'hBEEF_0006, 32'h0}, {5{5'd6}});
    rd_all(5'd6);

    // R4: collision, write port 1 wins
    tag = "R4";
    drive(2'b11, {5'd9, 5'd9}, {32'h1111_1111, 32'h0000_0000}, {5{5'd9}});
    rd_all(5'd9);
    drive(2'b11, {5'd31, 5'd31}, {32'h3131_3131, 32'h0F0F_0F0F}, '0);
    rd_all(5'd31);

    // R5: address 0 stays zero, other registers untouched
    tag = "R5";
    drive(2'b11, {5'd0, 5'd0}, {32'hFFFF_FFFF, 32'h1234_5678}, '0);
    rd_all(5'd0);
    drive(2'b00, '0, '0, {5'd0, 5'd9, 5'd5, 5'd6, 5'd31});

    // R8: last writer across cycles, both orders
    tag = "R8";
    drive(2'b10, {5'd12, 5'd0}, {32'h0000_0112, 32'h0}, '0);
    drive(2'b01, {5'd0, 5'd12}, {32'h0, 32'h0000_0012}, '0);
    rd_all(5'd12);
    drive(2'b01, {5'd0, 5'd13}, {32'h0, 32'h0000_0013}, '0);
    drive(2'b10, {5'd13, 5'd0}, {32'h0000_0113, 32'h0}, '0);
    rd_all(5'd13);

    // R7: random concurrent traffic on a narrow address set
    tag = "R7";
    for (int n = 0; n < 3000; n++) begin
      logic [1:0][4:0]  a;
      logic [1:0][31:0] d;
      logic [4:0][4:0]  r;
      for (int w = 0; w < NWR; w++) begin
        a[w] = 5'($urandom_range(0, 5));
        d[w] = $urandom;
      end
      for (int p = 0; p < NRD; p++) r[p] = 5'($urandom_range(0, 5));
      drive(2'($urandom), a, d, r);
    end
    drive(2'b00, '0, '0, '0);
    @(negedge clk);
    @(negedge clk);
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule